// File: doc/BRIEF.md
# I2C slave address matcher

This block decides whether the address phase of an I2C transfer selects this slave. A byte receiver upstream hands it each received byte with a one-cycle strobe. It also reports every START condition and says whether that START was a repeated one. The matcher compares the first byte after a START against several configured addresses. These are a primary address in 7-bit or 10-bit form, a secondary 7-bit address with a programmable don't-care mask on its low bits, and four reserved addresses, each with its own enable.

In 10-bit mode the matcher follows the two-byte write sequence: a header carrying the top two address bits, then a byte holding the low eight bits. It remembers a completed 10-bit write match for the rest of the transfer. A later read header after a repeated START then selects the slave for transmit. On a match it pulses a hit output for one cycle. It also latches a 7-bit match code, the transfer direction and the kind of address that matched. These values stay until the next START. Bytes that arrive after the address phase are left to the data path and do not affect the matcher.

Top module: `i2c_addr_matcher`

## Requirements
- R1: With the primary enabled in 7-bit mode, a first byte whose bits [7:1] equal the primary address hits. The code is bits [7:1], the direction is bit 0 (1 = read) and the source is 0. With the primary disabled that byte does not hit.
- R2: The secondary address (source 1) ignores as many low address bits as its 3-bit mask value states, so a value of 7 accepts any address. It never matches an address of the form 0000xxx or 1111xxx.
- R3: Four reserved addresses each have an enable bit: bit 0 is 0000000, bit 1 is 0001100, bit 2 is 1100001 and bit 3 is 0001000. An enabled one hits with source 2.
- R4: When several sources match a 7-bit byte, the primary wins over the secondary and the secondary wins over the reserved set.
- R5: In 10-bit mode, a header 11110 a9 a8 0 followed by a byte equal to a[7:0] hits. The code is 11110 a9 a8, the direction is 0 and the source is 0. A mismatching second byte gives no hit.
- R6: In 10-bit mode, a first byte whose bits [7:1] equal the low seven bits of the primary address never gives a primary hit.
- R7: A read header 11110 a9 a8 1 hits with direction 1 only after a repeated START, and only when a full 10-bit write match happened earlier in the same transfer. A non-repeated START removes that memory. So does any first byte other than this read header.
- R8: In a 10-bit match the direction comes from the header only, even when the low address byte has the pattern of a read header.
- R9: The hit output is high for exactly the one cycle after the byte strobe. Code, direction and source hold until the next START, which clears them to zero one cycle later. A START in the same cycle as a byte strobe wins, and that byte is not compared.
- R10: Bytes received after the address phase, up to the next START, cause no hit and leave the latched outputs unchanged.
- R11: After reset the hit output, code, direction and source are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | One-cycle pulse for each START condition |
| restartFlag | input | 1 | Qualifies startPulse as a repeated START |
| byteValid | input | 1 | One-cycle strobe marking rxByte as received |
| rxByte | input | 8 | Received byte, bit 0 is the R/W bit of an address byte |
| ownEn | input | 1 | Primary address enable |
| own10 | input | 1 | Primary address mode, 1 = 10-bit |
| ownAddr | input | 10 | Primary address (bits [6:0] used in 7-bit mode) |
| secEn | input | 1 | Secondary address enable |
| secAddr | input | 7 | Secondary 7-bit address |
| secMask | input | 3 | Number of secondary low bits ignored |
| resEn | input | 4 | Reserved address enables |
| addrHit | output | 1 | One-cycle match pulse |
| matchCode | output | 7 | Latched match code |
| readDir | output | 1 | Latched direction, 1 = slave transmits |
| hitSrc | output | 2 | Latched source: 0 primary, 1 secondary, 2 reserved |

## Verification
The bench builds the block with its default parameters: 7-bit and 10-bit address widths and a 3-bit secondary mask. With these widths every mask value, from an exact compare through partial masks to a full wildcard, can be set from the ports, and so can all four reserved enables. Transfers chained by repeated STARTs show how the 10-bit read memory is set and cleared. Overlapping configurations are chosen on purpose: a 10-bit address whose low bits form a secondary address, a low byte that looks like a read header, and one address enabled in several sources. These show that the code, direction and priority stay correct.

// File: rtl/i2cam_pkg.sv
package i2cam_pkg;
  localparam int BYTE_W  = 8;
  localparam int A7_W    = 7;
  localparam int A10_W   = 10;
  localparam int MASK_W  = 3;
  localparam int RES_N   = 4;
  localparam int SRC_W   = 2;
  localparam int TAG_W   = A7_W - (A10_W - A7_W - 1);
  localparam logic [TAG_W-1:0] TEN_TAG = 5'b11110;

  typedef enum logic [SRC_W-1:0] {
    SRC_PRI = 2'd0,
    SRC_SEC = 2'd1,
    SRC_RES = 2'd2
  } hit_src_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_e;

  // control to datapath strobes
  typedef struct packed {
    logic loadHit;
    logic clrOut;
    logic tenBit;
    logic dirRd;
  } dp_ctl_t;

  // datapath compare results to control
  typedef struct packed {
    logic hdrMatch;
    logic lowMatch;
    logic any7;
  } dp_stat_t;

  function automatic logic [A7_W-1:0] resAddr(input int idx);
    logic [A7_W-1:0] r;
    case (idx)
      0: r = 7'b0000000;
      1: r = 7'b0001100;
      2: r = 7'b1100001;
      default: r = 7'b0001000;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/i2cam_datapath.sv
module i2cam_datapath
  import i2cam_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [BYTE_W-1:0]    rxByte,
  input  logic                 ownEn,
  input  logic                 own10,
  input  logic [A10_W-1:0]     ownAddr,
  input  logic                 secEn,
  input  logic [A7_W-1:0]      secAddr,
  input  logic [MASK_W-1:0]    secMask,
  input  logic [RES_N-1:0]     resEn,
  input  dp_ctl_t              ctl,
  output dp_stat_t             stat,
  output logic                 addrHit,
  output logic [A7_W-1:0]      matchCode,
  output logic                 readDir,
  output logic [SRC_W-1:0]     hitSrc
);
  localparam int HI_W = A10_W - A7_W - 1;

  logic [A7_W-1:0]  rxAddr;
  logic             rwBit;
  logic [A7_W-1:0]  keepMask;
  logic             inResv;
  logic             priHit7;
  logic             secHit;
  logic [RES_N-1:0] resHitVec;
  logic             resHit;
  hit_src_e         srcSel;
  logic [A7_W-1:0]  tenCode;

  assign rxAddr  = rxByte[BYTE_W-1:1];
  assign rwBit   = rxByte[0];
  assign tenCode = {TEN_TAG, ownAddr[A10_W-1 -: HI_W]};

  always_comb begin
    keepMask = {A7_W{1'b1}} << secMask;
  end

  assign inResv  = (rxAddr[A7_W-1 -: 4] == 4'b0000) || (rxAddr[A7_W-1 -: 4] == 4'b1111);
  assign priHit7 = ownEn && !own10 && (rxAddr == ownAddr[A7_W-1:0]);
  assign secHit  = secEn && !inResv && (((rxAddr ^ secAddr) & keepMask) == '0);

  for (genvar i = 0; i < RES_N; i++) begin : g_res
    localparam logic [A7_W-1:0] RA = resAddr(i);
    assign resHitVec[i] = resEn[i] && (rxAddr == RA);
  end
  assign resHit = |resHitVec;

  always_comb begin
    if (priHit7)     srcSel = SRC_PRI;
    else if (secHit) srcSel = SRC_SEC;
    else             srcSel = SRC_RES;
  end

  always_comb begin
    stat.any7     = priHit7 || secHit || resHit;
    stat.hdrMatch = ownEn && own10 && (rxAddr == tenCode);
    stat.lowMatch = ownEn && own10 && (rxByte == ownAddr[BYTE_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrHit   <= 1'b0;
      matchCode <= '0;
      readDir   <= 1'b0;
      hitSrc    <= '0;
    end else begin
      addrHit <= ctl.loadHit;
      if (ctl.clrOut) begin
        matchCode <= '0;
        readDir   <= 1'b0;
        hitSrc    <= '0;
      end else if (ctl.loadHit) begin
        matchCode <= ctl.tenBit ? tenCode : rxAddr;
        readDir   <= ctl.tenBit ? ctl.dirRd : rwBit;
        hitSrc    <= ctl.tenBit ? SRC_PRI : srcSel;
      end
    end
  end
endmodule

// File: rtl/i2cam_control.sv
module i2cam_control
  import i2cam_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startPulse,
  input  logic     restartFlag,
  input  logic     byteValid,
  input  logic     rwBit,
  input  dp_stat_t stat,
  output dp_ctl_t  ctl
);
  phase_e phase;
  logic   tenArmed;

  always_comb begin
    ctl = '0;
    if (startPulse) begin
      ctl.clrOut = 1'b1;
    end else if (byteValid) begin
      case (phase)
        PH_FIRST: begin
          if (stat.hdrMatch) begin
            if (rwBit && tenArmed) begin
              ctl.loadHit = 1'b1;
              ctl.tenBit  = 1'b1;
              ctl.dirRd   = 1'b1;
            end
          end else if (stat.any7) begin
            ctl.loadHit = 1'b1;
          end
        end
        PH_SECOND: begin
          if (stat.lowMatch) begin
            ctl.loadHit = 1'b1;
            ctl.tenBit  = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      tenArmed <= 1'b0;
    end else if (startPulse) begin
      phase <= PH_FIRST;
      if (!restartFlag) tenArmed <= 1'b0;
    end else if (byteValid) begin
      case (phase)
        PH_FIRST: begin
          if (stat.hdrMatch && !rwBit) begin
            phase    <= PH_SECOND;
            tenArmed <= 1'b0;
          end else begin
            phase    <= PH_IDLE;
            tenArmed <= stat.hdrMatch && rwBit && tenArmed;
          end
        end
        PH_SECOND: begin
          phase    <= PH_IDLE;
          tenArmed <= stat.lowMatch;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
  import i2cam_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              restartFlag,
  input  logic              byteValid,
  input  logic [7:0]        rxByte,
  input  logic              ownEn,
  input  logic              own10,
  input  logic [9:0]        ownAddr,
  input  logic              secEn,
  input  logic [6:0]        secAddr,
  input  logic [2:0]        secMask,
  input  logic [3:0]        resEn,
  output logic              addrHit,
  output logic [6:0]        matchCode,
  output logic              readDir,
  output logic [1:0]        hitSrc
);
  dp_ctl_t  ctl;
  dp_stat_t stat;

  i2cam_control u_ctl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .restartFlag(restartFlag),
    .byteValid(byteValid), .rwBit(rxByte[0]), .stat(stat), .ctl(ctl)
  );

  i2cam_datapath u_dp (
    .clk(clk), .rstN(rstN), .rxByte(rxByte), .ownEn(ownEn), .own10(own10),
    .ownAddr(ownAddr), .secEn(secEn), .secAddr(secAddr), .secMask(secMask),
    .resEn(resEn), .ctl(ctl), .stat(stat), .addrHit(addrHit),
    .matchCode(matchCode), .readDir(readDir), .hitSrc(hitSrc)
  );
endmodule

// File: rtl/i2cam_checker.sv
module i2cam_checker (
  input logic       clk,
  input logic       rstN,
  input logic       startPulse,
  input logic       byteValid,
  input logic       own10,
  input logic       addrHit,
  input logic [6:0] matchCode,
  input logic       readDir,
  input logic [1:0] hitSrc
);
  // R9
  hit_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrHit |=> !addrHit);

  // R9
  start_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (matchCode == 7'd0 && !readDir && hitSrc == 2'd0 && !addrHit));

  // R10
  hold_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!addrHit && !$past(startPulse)) |-> ($stable(matchCode) && $stable(readDir) && $stable(hitSrc)));

  // R10
  hit_needs_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrHit |-> $past(byteValid));

  // R5
  ten_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrHit && own10 && hitSrc == 2'd0) |-> (matchCode[6:2] == 5'b11110));

  // R2
  sec_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrHit && hitSrc == 2'd1) |-> (matchCode[6:3] != 4'b0000 && matchCode[6:3] != 4'b1111));

  // R3
  res_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrHit && hitSrc == 2'd2) |-> (matchCode == 7'b0000000 || matchCode == 7'b0001100 ||
                                     matchCode == 7'b1100001 || matchCode == 7'b0001000));
endmodule

bind i2c_addr_matcher i2cam_checker u_chk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .byteValid(byteValid),
  .own10(own10), .addrHit(addrHit), .matchCode(matchCode), .readDir(readDir),
  .hitSrc(hitSrc)
);

// File: tb/sim_i2c_addr_matcher.sv
`timescale 1ns/1ps
module sim_i2c_addr_matcher;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startPulse = 1'b0;
  logic       restartFlag = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic       ownEn = 1'b0;
  logic       own10 = 1'b0;
  logic [9:0] ownAddr = '0;
  logic       secEn = 1'b0;
  logic [6:0] secAddr = '0;
  logic [2:0] secMask = '0;
  logic [3:0] resEn = '0;
  logic       addrHit;
  logic [6:0] matchCode;
  logic       readDir;
  logic [1:0] hitSrc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  i2c_addr_matcher u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .restartFlag(restartFlag),
    .byteValid(byteValid), .rxByte(rxByte), .ownEn(ownEn), .own10(own10),
    .ownAddr(ownAddr), .secEn(secEn), .secAddr(secAddr), .secMask(secMask),
    .resEn(resEn), .addrHit(addrHit), .matchCode(matchCode), .readDir(readDir),
    .hitSrc(hitSrc)
  );

  typedef struct packed {
    logic [3:0] rq;
    logic       oEn;
    logic       o10;
    logic [9:0] oA;
    logic       sEn;
    logic [6:0] sA;
    logic [2:0] sM;
    logic [3:0] rE;
    logic       rep;
    logic [7:0] b0;
    logic       two;
    logic [7:0] b1;
    logic       eHit;
    logic [6:0] eCode;
    logic       eDir;
    logic [1:0] eSrc;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 1'b1,1'b0,10'h052, 1'b1,7'h30,3'd0,4'h0, 1'b0,8'hA5,1'b0,8'h00, 1'b1,7'h52,1'b1,2'd0}, // R1
    '{4'd2, 1'b1,1'b0,10'h052, 1'b1,7'h30,3'd0,4'h0, 1'b0,8'h60,1'b0,8'h00, 1'b1,7'h30,1'b0,2'd1}, // R2
    '{4'd2, 1'b1,1'b0,10'h052, 1'b1,7'h30,3'd0,4'h0, 1'b0,8'h62,1'b0,8'h00, 1'b0,7'h00,1'b0,2'd0}, // R2
    '{4'd2, 1'b1,1'b0,10'h052, 1'b1,7'h30,3'd2,4'h0, 1'b0,8'h67,1'b0,8'h00, 1'b1,7'h33,1'b1,2'd1}, // R2
    '{4'd2, 1'b1,1'b0,10'h052, 1'b1,7'h30,3'd2,4'h0, 1'b0,8'h68,1'b0,8'h00, 1'b0,7'h00,1'b0,2'd0}, // R2
    '{4'd2, 1'b1,1'b0,10'h052, 1'b1,7'h30,3'd7,4'h0, 1'b0,8'hD6,1'b0,8'h00, 1'b1,7'h6B,1'b0,2'd1}, // R2
    '{4'd2, 1'b1,1'b0,10'h052, 1'b1,7'h30,3'd7,4'h0, 1'b0,8'h0A,1'b0,8'h00, 1'b0,7'h00,1'b0,2'd0}, // R2
    '{4'd2, 1'b1,1'b0,10'h052, 1'b1,7'h30,3'd7,4'h0, 1'b0,8'hF8,1'b0,8'h00, 1'b0,7'h00,1'b0,2'd0}, // R2
    '{4'd4, 1'b1,1'b0,10'h030, 1'b1,7'h30,3'd0,4'h0, 1'b0,8'h60,1'b0,8'h00, 1'b1,7'h30,1'b0,2'd0}, // R4
    '{4'd3, 1'b1,1'b0,10'h052, 1'b0,7'h30,3'd0,4'h1, 1'b0,8'h00,1'b0,8'h00, 1'b1,7'h00,1'b0,2'd2}, // R3
    '{4'd3, 1'b1,1'b0,10'h052, 1'b0,7'h30,3'd0,4'hE, 1'b0,8'h00,1'b0,8'h00, 1'b0,7'h00,1'b0,2'd0}, // R3
    '{4'd3, 1'b1,1'b0,10'h052, 1'b0,7'h30,3'd0,4'h2, 1'b0,8'h19,1'b0,8'h00, 1'b1,7'h0C,1'b1,2'd2}, // R3
    '{4'd3, 1'b1,1'b0,10'h052, 1'b0,7'h30,3'd0,4'h4, 1'b0,8'hC2,1'b0,8'h00, 1'b1,7'h61,1'b0,2'd2}, // R3
    '{4'd3, 1'b1,1'b0,10'h052, 1'b0,7'h30,3'd0,4'h8, 1'b0,8'h10,1'b0,8'h00, 1'b1,7'h08,1'b0,2'd2}, // R3
    '{4'd4, 1'b1,1'b0,10'h052, 1'b1,7'h30,3'd7,4'h4, 1'b0,8'hC2,1'b0,8'h00, 1'b1,7'h61,1'b0,2'd1}, // R4
    '{4'd5, 1'b1,1'b1,10'h3A5, 1'b0,7'h00,3'd0,4'h0, 1'b0,8'hF6,1'b1,8'hA5, 1'b1,7'h7B,1'b0,2'd0}, // R5
    '{4'd7, 1'b1,1'b1,10'h3A5, 1'b0,7'h00,3'd0,4'h0, 1'b1,8'hF7,1'b0,8'h00, 1'b1,7'h7B,1'b1,2'd0}, // R7
    '{4'd7, 1'b1,1'b1,10'h3A5, 1'b0,7'h00,3'd0,4'h0, 1'b0,8'hF7,1'b0,8'h00, 1'b0,7'h00,1'b0,2'd0}, // R7
    '{4'd5, 1'b1,1'b1,10'h3A5, 1'b0,7'h00,3'd0,4'h0, 1'b0,8'hF6,1'b1,8'hA4, 1'b0,7'h00,1'b0,2'd0}, // R5
    '{4'd7, 1'b1,1'b1,10'h3A5, 1'b0,7'h00,3'd0,4'h0, 1'b1,8'hF7,1'b0,8'h00, 1'b0,7'h00,1'b0,2'd0}, // R7
    '{4'd6, 1'b1,1'b1,10'h3A5, 1'b0,7'h00,3'd0,4'h0, 1'b0,8'h4A,1'b0,8'h00, 1'b0,7'h00,1'b0,2'd0}, // R6
    '{4'd6, 1'b1,1'b1,10'h3A5, 1'b1,7'h25,3'd0,4'h0, 1'b0,8'h4A,1'b0,8'h00, 1'b1,7'h25,1'b0,2'd1}, // R6
    '{4'd8, 1'b1,1'b1,10'h0F1, 1'b1,7'h30,3'd0,4'h0, 1'b0,8'hF0,1'b1,8'hF1, 1'b1,7'h78,1'b0,2'd0}, // R8
    '{4'd8, 1'b1,1'b1,10'h0F1, 1'b1,7'h30,3'd0,4'h0, 1'b1,8'hF1,1'b0,8'h00, 1'b1,7'h78,1'b1,2'd0}, // R8
    '{4'd7, 1'b1,1'b1,10'h0F1, 1'b1,7'h30,3'd0,4'h0, 1'b1,8'h60,1'b0,8'h00, 1'b1,7'h30,1'b0,2'd1}, // R7
    '{4'd7, 1'b1,1'b1,10'h0F1, 1'b1,7'h30,3'd0,4'h0, 1'b1,8'hF1,1'b0,8'h00, 1'b0,7'h00,1'b0,2'd0}, // R7
    '{4'd1, 1'b0,1'b0,10'h052, 1'b0,7'h30,3'd0,4'h0, 1'b0,8'hA4,1'b0,8'h00, 1'b0,7'h00,1'b0,2'd0}  // R1
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic startXfer(input logic rep);
    @(negedge clk);
    startPulse  = 1'b1;
    restartFlag = rep;
    @(negedge clk);
    startPulse  = 1'b0;
    restartFlag = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, inout logic seen);
    @(negedge clk);
    rxByte    = b;
    byteValid = 1'b1;
    @(negedge clk);
    byteValid = 1'b0;
    seen = seen | addrHit;
  endtask

  task automatic setCfg(input vec_t v);
    ownEn   = v.oEn;
    own10   = v.o10;
    ownAddr = v.oA;
    secEn   = v.sEn;
    secAddr = v.sA;
    secMask = v.sM;
    resEn   = v.rE;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    logic seen;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk({addrHit, matchCode, readDir, hitSrc} == '0, "R11",
        {addrHit, matchCode, readDir, hitSrc}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk({addrHit, matchCode, readDir, hitSrc} == '0, "R11",
        {addrHit, matchCode, readDir, hitSrc}, 0);

    for (int i = 0; i < NV; i++) begin
      setCfg(VECS[i]);
      startXfer(VECS[i].rep);
      seen = 1'b0;
      sendByte(VECS[i].b0, seen);
      if (VECS[i].two) sendByte(VECS[i].b1, seen);
      chk({seen, matchCode, readDir, hitSrc} ==
          {VECS[i].eHit, VECS[i].eCode, VECS[i].eDir, VECS[i].eSrc},
          $sformatf("R%0d vec%0d", VECS[i].rq, i),
          {seen, matchCode, readDir, hitSrc},
          {VECS[i].eHit, VECS[i].eCode, VECS[i].eDir, VECS[i].eSrc});
    end

    // R9: START and byte in the same cycle, START wins
    setCfg(VECS[0]);
    @(negedge clk);
    startPulse = 1'b1;
    byteValid  = 1'b1;
    rxByte     = 8'hA5;
    @(negedge clk);
    startPulse = 1'b0;
    byteValid  = 1'b0;
    chk(!addrHit && matchCode == 7'h00, "R9", {addrHit, matchCode}, 0);

    // R9: the hit pulse lasts one cycle, outputs latch
    @(negedge clk);
    rxByte    = 8'hA5;
    byteValid = 1'b1;
    @(negedge clk);
    byteValid = 1'b0;
    chk(addrHit == 1'b1, "R9", addrHit, 1);
    @(negedge clk);
    chk(addrHit == 1'b0, "R9", addrHit, 0);
    repeat (5) @(negedge clk);
    chk({matchCode, readDir, hitSrc} == {7'h52, 1'b1, 2'd0}, "R9",
        {matchCode, readDir, hitSrc}, {7'h52, 1'b1, 2'd0});

    // R10: bytes after the address phase are ignored
    seen = 1'b0;
    sendByte(8'hA4, seen);
    sendByte(8'h60, seen);
    chk(!seen && {matchCode, readDir, hitSrc} == {7'h52, 1'b1, 2'd0}, "R10",
        {seen, matchCode, readDir, hitSrc}, {1'b0, 7'h52, 1'b1, 2'd0});

    // R9: the next START clears the latched outputs
    startXfer(1'b0);
    chk({matchCode, readDir, hitSrc} == '0, "R9", {matchCode, readDir, hitSrc}, 0);

    done = 1'b1;
    finishRun();
  end
endmodule